// File: doc/BRIEF.md
# Fixed-Format Instruction Decoder

This block is the decode stage front end for a word-oriented processor whose instructions are all 32 bits with one fixed layout. From the top down they hold a 6-bit operation code, a 5-bit destination register index, a 5-bit source register index and a 16-bit general field. The decoder is purely combinational. It splits the word into its fields and sign-extends the general field to 32 bits. It then turns the operation code into the control bundle that the execute, memory and register-write stages consume.

The 16-bit general field can carry an immediate value, an absolute address, a displacement or a second source register index. The decoder always presents all of these views: the second source index comes from the low five bits, and the full field comes out sign-extended. Downstream logic chooses the view it needs using the operand-B select, the addressing mode and the jump kind. Arithmetic and logic operations exist in two forms, immediate and register-register. The two forms share one 4-bit ALU code, and the register form sits exactly 22 opcodes above the immediate form. Any operation code outside the defined map raises `illegal`, and every enable is held low for that word.

Top module: `instr_decoder`

## Requirements
- R1: `rd_idx` is instr[25:21], `rs_idx` is instr[20:16] and `rt_idx` is instr[4:0], for every operation code.
- R2: `imm_sext` is instr[15:0] sign-extended to 32 bits (bit 15 copied into bits 31:16).
- R3: Operation codes 10 to 25 are immediate ALU forms. They give `alu_valid`=1, `opb_imm`=1, `reg_we`=1 and `alu_op` = code-10, where the ALU codes 0..15 mean add, sub, mul, div, and, or, xor, eq, ne, lt, le, gt, ge, shl, shr, mod. No memory enable is raised.
- R4: Operation codes 32 to 47 are register-register ALU forms. They give `alu_valid`=1, `opb_imm`=0, `reg_we`=1 and `alu_op` = code-32, in the same ALU code order as R3.
- R5: Loads are code 1 (absolute), code 2 (displacement) and code 48 (indexed). Each gives `mem_rd`=1 and `reg_we`=1, with `addr_mode` 1, 2 or 3 respectively (0 means no address).
- R6: Stores are code 3 (absolute), code 4 (displacement) and code 49 (indexed). Each gives `mem_wr`=1 and `reg_we`=0, with `addr_mode` 1, 2 or 3.
- R7: The `jump_kind` field is 1 for code 6 (unconditional), 2 for code 7 (jump and link), 3 for code 8 (taken if register nonzero), 4 for code 9 (taken if register zero) and 5 for code 50 (return through register). Only code 7 raises `reg_we`. No jump raises a memory enable.
- R8: Code 52 (push) gives `stack_op`=1, `mem_wr`=1 and `reg_we`=1. Code 53 (pop) gives `stack_op`=2, `mem_rd`=1 and `reg_we`=1. Both give `addr_mode`=0.
- R9: Code 51 raises `is_trap` and no other control output.
- R10: Codes 0 and 5 are no-operations. Every control output is 0 and `illegal` is 0.
- R11: Codes 26 to 31 and 54 to 63 raise `illegal` and force every other control output to 0.
- R12: A destination index of 0 is decoded like any other. `reg_we` is still raised, because the register file discards writes to register 0.
- R13: `mem_rd` and `mem_wr` are never high together. Outside the ALU forms, `alu_valid`, `opb_imm` and `alu_op` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| rd_idx | output | 5 | Destination register index |
| rs_idx | output | 5 | First source register index |
| rt_idx | output | 5 | Second source register index (low bits of the general field) |
| imm_sext | output | 32 | General field, sign-extended |
| alu_op | output | 4 | ALU operation code |
| alu_valid | output | 1 | Word is an ALU operation |
| opb_imm | output | 1 | Operand B is the immediate rather than `rt_idx` |
| reg_we | output | 1 | A register write is requested |
| mem_rd | output | 1 | Memory read requested |
| mem_wr | output | 1 | Memory write requested |
| addr_mode | output | 2 | 0 none, 1 absolute, 2 displacement, 3 indexed |
| jump_kind | output | 3 | 0 none, 1 always, 2 link, 3 if nonzero, 4 if zero, 5 return |
| stack_op | output | 2 | 0 none, 1 push, 2 pop |
| is_trap | output | 1 | Trap instruction |
| illegal | output | 1 | Operation code outside the defined map |

## Verification
The internal state here is the group into which the classifier sorts an operation code. A word placed in the wrong group shows up at once, in the same cycle the word is applied. Examples are a range boundary that is off by one, or a free slot between the two ALU ranges that is treated as legal. Such a fault appears as a wrong enable, mode or ALU code on the ports. For that reason every one of the 64 operation codes is applied, with the edges 9/10, 25/26, 31/32, 47/48 and 53/54 included, and each control output is compared. Field extraction is checked with patterns that toggle the sign bit of the general field and use a destination index of zero.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;

    localparam int INSTR_W = 32;
    localparam int OP_W    = 6;
    localparam int REG_W   = 5;
    localparam int D_W     = 16;
    localparam int XLEN    = 32;
    localparam int ALU_N   = 16;
    localparam int ALU_SEL_W = $clog2(ALU_N);

    // Operation codes whose position matters to the decode.
    localparam logic [OP_W-1:0] OPC_NOP_A     = 6'd0;
    localparam logic [OP_W-1:0] OPC_LD_ABS    = 6'd1;
    localparam logic [OP_W-1:0] OPC_LD_DISP   = 6'd2;
    localparam logic [OP_W-1:0] OPC_ST_ABS    = 6'd3;
    localparam logic [OP_W-1:0] OPC_ST_DISP   = 6'd4;
    localparam logic [OP_W-1:0] OPC_NOP_B     = 6'd5;
    localparam logic [OP_W-1:0] OPC_JUMP      = 6'd6;
    localparam logic [OP_W-1:0] OPC_JLINK     = 6'd7;
    localparam logic [OP_W-1:0] OPC_JNZ       = 6'd8;
    localparam logic [OP_W-1:0] OPC_JZ        = 6'd9;
    localparam logic [OP_W-1:0] OPC_ALU_IMM0  = 6'd10;
    localparam logic [OP_W-1:0] OPC_ALU_REG0  = 6'd32;
    localparam logic [OP_W-1:0] OPC_LD_IDX    = 6'd48;
    localparam logic [OP_W-1:0] OPC_ST_IDX    = 6'd49;
    localparam logic [OP_W-1:0] OPC_RETURN    = 6'd50;
    localparam logic [OP_W-1:0] OPC_TRAP      = 6'd51;
    localparam logic [OP_W-1:0] OPC_PUSH      = 6'd52;
    localparam logic [OP_W-1:0] OPC_POP       = 6'd53;

    typedef enum logic [ALU_SEL_W-1:0] {
        ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV,
        ALU_AND, ALU_OR,  ALU_XOR, ALU_EQ,
        ALU_NE,  ALU_LT,  ALU_LE,  ALU_GT,
        ALU_GE,  ALU_SHL, ALU_SHR, ALU_MOD
    } alu_op_e;

    typedef enum logic [1:0] {
        AM_NONE, AM_ABS, AM_DISP, AM_INDEX
    } addr_mode_e;

    typedef enum logic [2:0] {
        JK_NONE, JK_ALWAYS, JK_LINK, JK_IF_NZ, JK_IF_Z, JK_RETURN
    } jump_kind_e;

    typedef enum logic [1:0] {
        SK_NONE, SK_PUSH, SK_POP
    } stack_op_e;

    typedef enum logic [3:0] {
        GRP_NOP, GRP_LOAD, GRP_STORE, GRP_JUMP, GRP_ALU_IMM,
        GRP_ALU_REG, GRP_TRAP, GRP_STACK, GRP_BAD
    } op_group_e;

    typedef struct packed {
        alu_op_e    alu_op;
        logic       alu_valid;
        logic       opb_imm;
        logic       reg_we;
        logic       mem_rd;
        logic       mem_wr;
        addr_mode_e addr_mode;
        jump_kind_e jump_kind;
        stack_op_e  stack_op;
        logic       is_trap;
        logic       illegal;
    } ctrl_t;

endpackage

// File: rtl/instr_fields.sv
module instr_fields
    import instr_dec_pkg::*;
#(
    parameter int IW = INSTR_W,
    parameter int OW = OP_W,
    parameter int RW = REG_W,
    parameter int DW = D_W,
    parameter int XW = XLEN
) (
    input  logic [IW-1:0] instr,
    output logic [OW-1:0] opcode,
    output logic [RW-1:0] rd_idx,
    output logic [RW-1:0] rs_idx,
    output logic [RW-1:0] rt_idx,
    output logic [XW-1:0] imm_sext
);
    localparam int OP_LSB = IW - OW;
    localparam int RD_LSB = OP_LSB - RW;
    localparam int RS_LSB = RD_LSB - RW;

    logic [DW-1:0] dfield;

    assign opcode = instr[IW-1:OP_LSB];
    assign rd_idx = instr[OP_LSB-1:RD_LSB];
    assign rs_idx = instr[RD_LSB-1:RS_LSB];
    assign dfield = instr[DW-1:0];
    assign rt_idx = dfield[RW-1:0];

    generate
        if (XW > DW) begin : g_ext
            assign imm_sext = {{(XW-DW){dfield[DW-1]}}, dfield};
        end else begin : g_trunc
            assign imm_sext = dfield[XW-1:0];
        end
    endgenerate

endmodule

// File: rtl/op_classifier.sv
module op_classifier
    import instr_dec_pkg::*;
#(
    parameter int OW       = OP_W,
    parameter int IMM_BASE = 10,
    parameter int REG_BASE = 32,
    parameter int N_ALU    = ALU_N
) (
    input  logic [OW-1:0]        opcode,
    output op_group_e            group,
    output logic [ALU_SEL_W-1:0] alu_idx
);
    localparam int IMM_LAST = IMM_BASE + N_ALU - 1;
    localparam int REG_LAST = REG_BASE + N_ALU - 1;

    logic [OW-1:0] off_imm;
    logic [OW-1:0] off_reg;
    logic          in_imm;
    logic          in_reg;

    assign in_imm  = (int'(opcode) >= IMM_BASE) && (int'(opcode) <= IMM_LAST);
    assign in_reg  = (int'(opcode) >= REG_BASE) && (int'(opcode) <= REG_LAST);
    assign off_imm = opcode - OW'(IMM_BASE);
    assign off_reg = opcode - OW'(REG_BASE);

    always_comb begin
        alu_idx = '0;
        if (in_imm) begin
            group   = GRP_ALU_IMM;
            alu_idx = off_imm[ALU_SEL_W-1:0];
        end else if (in_reg) begin
            group   = GRP_ALU_REG;
            alu_idx = off_reg[ALU_SEL_W-1:0];
        end else begin
            unique case (opcode)
                OPC_NOP_A, OPC_NOP_B:                group = GRP_NOP;
                OPC_LD_ABS, OPC_LD_DISP, OPC_LD_IDX: group = GRP_LOAD;
                OPC_ST_ABS, OPC_ST_DISP, OPC_ST_IDX: group = GRP_STORE;
                OPC_JUMP, OPC_JLINK, OPC_JNZ, OPC_JZ,
                OPC_RETURN:                          group = GRP_JUMP;
                OPC_TRAP:                            group = GRP_TRAP;
                OPC_PUSH, OPC_POP:                   group = GRP_STACK;
                default:                             group = GRP_BAD;
            endcase
        end
    end

endmodule

// File: rtl/ctrl_gen.sv
module ctrl_gen
    import instr_dec_pkg::*;
#(
    parameter int OW = OP_W
) (
    input  op_group_e            group,
    input  logic [OW-1:0]        opcode,
    input  logic [ALU_SEL_W-1:0] alu_idx,
    output ctrl_t                ctrl
);
    always_comb begin
        ctrl = '0;
        unique case (group)
            GRP_NOP: begin
            end
            GRP_ALU_IMM: begin
                ctrl.alu_valid = 1'b1;
                ctrl.opb_imm   = 1'b1;
                ctrl.reg_we    = 1'b1;
                ctrl.alu_op    = alu_op_e'(alu_idx);
            end
            GRP_ALU_REG: begin
                ctrl.alu_valid = 1'b1;
                ctrl.reg_we    = 1'b1;
                ctrl.alu_op    = alu_op_e'(alu_idx);
            end
            GRP_LOAD: begin
                ctrl.mem_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                unique case (opcode)
                    OPC_LD_ABS:  ctrl.addr_mode = AM_ABS;
                    OPC_LD_DISP: ctrl.addr_mode = AM_DISP;
                    default:     ctrl.addr_mode = AM_INDEX;
                endcase
            end
            GRP_STORE: begin
                ctrl.mem_wr = 1'b1;
                unique case (opcode)
                    OPC_ST_ABS:  ctrl.addr_mode = AM_ABS;
                    OPC_ST_DISP: ctrl.addr_mode = AM_DISP;
                    default:     ctrl.addr_mode = AM_INDEX;
                endcase
            end
            GRP_JUMP: begin
                unique case (opcode)
                    OPC_JUMP:  ctrl.jump_kind = JK_ALWAYS;
                    OPC_JLINK: begin
                        ctrl.jump_kind = JK_LINK;
                        ctrl.reg_we    = 1'b1;
                    end
                    OPC_JNZ:   ctrl.jump_kind = JK_IF_NZ;
                    OPC_JZ:    ctrl.jump_kind = JK_IF_Z;
                    default:   ctrl.jump_kind = JK_RETURN;
                endcase
            end
            GRP_TRAP: begin
                ctrl.is_trap = 1'b1;
            end
            GRP_STACK: begin
                ctrl.reg_we = 1'b1;
                if (opcode == OPC_PUSH) begin
                    ctrl.stack_op = SK_PUSH;
                    ctrl.mem_wr   = 1'b1;
                end else begin
                    ctrl.stack_op = SK_POP;
                    ctrl.mem_rd   = 1'b1;
                end
            end
            default: begin
                ctrl.illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import instr_dec_pkg::*;
(
    input  logic [31:0] instr,
    output logic [4:0]  rd_idx,
    output logic [4:0]  rs_idx,
    output logic [4:0]  rt_idx,
    output logic [31:0] imm_sext,
    output logic [3:0]  alu_op,
    output logic        alu_valid,
    output logic        opb_imm,
    output logic        reg_we,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [1:0]  addr_mode,
    output logic [2:0]  jump_kind,
    output logic [1:0]  stack_op,
    output logic        is_trap,
    output logic        illegal
);
    logic [OP_W-1:0]      opcode;
    op_group_e            group;
    logic [ALU_SEL_W-1:0] alu_idx;
    ctrl_t                ctrl;

    instr_fields #(
        .IW(INSTR_W), .OW(OP_W), .RW(REG_W), .DW(D_W), .XW(XLEN)
    ) u_fields (
        .instr    (instr),
        .opcode   (opcode),
        .rd_idx   (rd_idx),
        .rs_idx   (rs_idx),
        .rt_idx   (rt_idx),
        .imm_sext (imm_sext)
    );

    op_classifier #(
        .OW(OP_W), .IMM_BASE(int'(OPC_ALU_IMM0)),
        .REG_BASE(int'(OPC_ALU_REG0)), .N_ALU(ALU_N)
    ) u_class (
        .opcode  (opcode),
        .group   (group),
        .alu_idx (alu_idx)
    );

    ctrl_gen #(.OW(OP_W)) u_ctrl (
        .group   (group),
        .opcode  (opcode),
        .alu_idx (alu_idx),
        .ctrl    (ctrl)
    );

    assign alu_op    = ctrl.alu_op;
    assign alu_valid = ctrl.alu_valid;
    assign opb_imm   = ctrl.opb_imm;
    assign reg_we    = ctrl.reg_we;
    assign mem_rd    = ctrl.mem_rd;
    assign mem_wr    = ctrl.mem_wr;
    assign addr_mode = ctrl.addr_mode;
    assign jump_kind = ctrl.jump_kind;
    assign stack_op  = ctrl.stack_op;
    assign is_trap   = ctrl.is_trap;
    assign illegal   = ctrl.illegal;

endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk (
    input logic [31:0] instr,
    input logic [3:0]  alu_op,
    input logic        alu_valid,
    input logic        opb_imm,
    input logic        reg_we,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [1:0]  addr_mode,
    input logic [2:0]  jump_kind,
    input logic [1:0]  stack_op,
    input logic        is_trap,
    input logic        illegal
);
    always_comb begin
        // R11
        illegal_quiet_chk: assert (!illegal || !(reg_we || mem_rd || mem_wr ||
            alu_valid || is_trap || (addr_mode != 2'd0) ||
            (jump_kind != 3'd0) || (stack_op != 2'd0)))
            else $error("illegal word raised a control output");
        // R13
        no_rd_wr_chk: assert (!(mem_rd && mem_wr))
            else $error("read and write requested together");
        // R13
        opb_needs_alu_chk: assert (alu_valid || (!opb_imm && alu_op == 4'd0))
            else $error("ALU fields set outside ALU group");
        // R3
        alu_writes_chk: assert (!alu_valid || (reg_we && !mem_rd && !mem_wr))
            else $error("ALU word without register write");
        // R7
        jump_no_mem_chk: assert ((jump_kind == 3'd0) || (!mem_rd && !mem_wr && !alu_valid))
            else $error("jump with memory or ALU enable");
        // R8
        stack_no_mode_chk: assert ((stack_op == 2'd0) || (addr_mode == 2'd0 && (mem_rd || mem_wr)))
            else $error("stack op with address mode or without memory access");
        // R9
        class_onehot_chk: assert ($onehot0({alu_valid, (jump_kind != 3'd0),
            (stack_op != 2'd0), is_trap, illegal, (addr_mode != 2'd0)}))
            else $error("more than one instruction class active");
    end

endmodule

bind instr_decoder instr_decoder_chk u_chk (
    .instr     (instr),
    .alu_op    (alu_op),
    .alu_valid (alu_valid),
    .opb_imm   (opb_imm),
    .reg_we    (reg_we),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .addr_mode (addr_mode),
    .jump_kind (jump_kind),
    .stack_op  (stack_op),
    .is_trap   (is_trap),
    .illegal   (illegal)
);

// File: tb/instr_decoder_tb.sv
module instr_decoder_tb;

    logic        clk = 1'b0;
    logic [31:0] instr = 32'd0;
    logic [4:0]  rd_idx, rs_idx, rt_idx;
    logic [31:0] imm_sext;
    logic [3:0]  alu_op;
    logic        alu_valid, opb_imm, reg_we, mem_rd, mem_wr, is_trap, illegal;
    logic [1:0]  addr_mode, stack_op;
    logic [2:0]  jump_kind;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    instr_decoder u_dut (
        .instr(instr), .rd_idx(rd_idx), .rs_idx(rs_idx), .rt_idx(rt_idx),
        .imm_sext(imm_sext), .alu_op(alu_op), .alu_valid(alu_valid),
        .opb_imm(opb_imm), .reg_we(reg_we), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .addr_mode(addr_mode), .jump_kind(jump_kind), .stack_op(stack_op),
        .is_trap(is_trap), .illegal(illegal)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] op, input logic [4:0] rd,
                         input logic [4:0] rs, input logic [15:0] d);
        @(posedge clk);
        instr = {op, rd, rs, d};
        @(negedge clk);
    endtask

    // Expected control for one operation code, written from the requirements.
    task automatic check_ctrl(input string req, input int op);
        logic [3:0] e_alu = 4'd0;
        logic e_av = 0, e_imm = 0, e_we = 0, e_rd = 0, e_wr = 0, e_trap = 0, e_ill = 0;
        logic [1:0] e_am = 2'd0, e_sk = 2'd0;
        logic [2:0] e_jk = 3'd0;
        if (op >= 10 && op <= 25) begin
            e_av = 1; e_imm = 1; e_we = 1; e_alu = 4'(op - 10);
        end else if (op >= 32 && op <= 47) begin
            e_av = 1; e_we = 1; e_alu = 4'(op - 32);
        end else begin
            case (op)
                0, 5: ;
                1:  begin e_rd = 1; e_we = 1; e_am = 2'd1; end
                2:  begin e_rd = 1; e_we = 1; e_am = 2'd2; end
                48: begin e_rd = 1; e_we = 1; e_am = 2'd3; end
                3:  begin e_wr = 1; e_am = 2'd1; end
                4:  begin e_wr = 1; e_am = 2'd2; end
                49: begin e_wr = 1; e_am = 2'd3; end
                6:  e_jk = 3'd1;
                7:  begin e_jk = 3'd2; e_we = 1; end
                8:  e_jk = 3'd3;
                9:  e_jk = 3'd4;
                50: e_jk = 3'd5;
                51: e_trap = 1;
                52: begin e_sk = 2'd1; e_wr = 1; e_we = 1; end
                53: begin e_sk = 2'd2; e_rd = 1; e_we = 1; end
                default: e_ill = 1;
            endcase
        end
        chk(req, $sformatf("op%0d alu_op", op),    32'(alu_op),    32'(e_alu));
        chk(req, $sformatf("op%0d alu_valid", op), 32'(alu_valid), 32'(e_av));
        chk(req, $sformatf("op%0d opb_imm", op),   32'(opb_imm),   32'(e_imm));
        chk(req, $sformatf("op%0d reg_we", op),    32'(reg_we),    32'(e_we));
        chk(req, $sformatf("op%0d mem_rd", op),    32'(mem_rd),    32'(e_rd));
        chk(req, $sformatf("op%0d mem_wr", op),    32'(mem_wr),    32'(e_wr));
        chk(req, $sformatf("op%0d addr_mode", op), 32'(addr_mode), 32'(e_am));
        chk(req, $sformatf("op%0d jump_kind", op), 32'(jump_kind), 32'(e_jk));
        chk(req, $sformatf("op%0d stack_op", op),  32'(stack_op),  32'(e_sk));
        chk(req, $sformatf("op%0d is_trap", op),   32'(is_trap),   32'(e_trap));
        chk(req, $sformatf("op%0d illegal", op),   32'(illegal),   32'(e_ill));
    endtask

    task automatic run_ops(input string req, input int lo, input int hi);
        for (int op = lo; op <= hi; op++) begin
            drive(6'(op), 5'(op + 3), 5'(op + 17), 16'(op * 16'h0913));
            check_ctrl(req, op);
        end
    endtask

    // R1 R2: field extraction and sign extension
    task automatic t_fields();
        drive(6'd10, 5'd31, 5'd0, 16'h7FFF);
        chk("R1", "rd", 32'(rd_idx), 32'd31);
        chk("R1", "rs", 32'(rs_idx), 32'd0);
        chk("R1", "rt", 32'(rt_idx), 32'h1F);
        chk("R2", "imm pos", imm_sext, 32'h0000_7FFF);
        drive(6'd40, 5'd0, 5'd21, 16'h8000);
        chk("R1", "rd", 32'(rd_idx), 32'd0);
        chk("R1", "rs", 32'(rs_idx), 32'd21);
        chk("R1", "rt", 32'(rt_idx), 32'd0);
        chk("R2", "imm min", imm_sext, 32'hFFFF_8000);
        drive(6'd63, 5'd10, 5'd5, 16'hFFF6);
        chk("R1", "rt illegal", 32'(rt_idx), 32'h16);
        chk("R2", "imm neg", imm_sext, 32'hFFFF_FFF6);
        drive(6'd1, 5'd7, 5'd9, 16'h0064);
        chk("R2", "imm addr", imm_sext, 32'h0000_0064);
    endtask

    task automatic t_alu_imm(); run_ops("R3", 10, 25); endtask
    task automatic t_alu_reg(); run_ops("R4", 32, 47); endtask

    task automatic t_mem();
        run_ops("R5", 1, 2);   run_ops("R5", 48, 48);
        run_ops("R6", 3, 4);   run_ops("R6", 49, 49);
    endtask

    task automatic t_jumps();
        run_ops("R7", 6, 9);   run_ops("R7", 50, 50);
    endtask

    task automatic t_stack_trap();
        run_ops("R8", 52, 53);
        run_ops("R9", 51, 51);
    endtask

    task automatic t_nop();
        run_ops("R10", 0, 0);  run_ops("R10", 5, 5);
    endtask

    task automatic t_illegal();
        run_ops("R11", 26, 31); run_ops("R11", 54, 63);
    endtask

    // R12: destination 0 still requests a write
    task automatic t_dest_zero();
        drive(6'd10, 5'd0, 5'd3, 16'h0001);
        chk("R12", "rd zero", 32'(rd_idx), 32'd0);
        chk("R12", "we imm", 32'(reg_we), 32'd1);
        drive(6'd1, 5'd0, 5'd0, 16'h0020);
        chk("R12", "we load", 32'(reg_we), 32'd1);
        drive(6'd7, 5'd0, 5'd0, 16'h0040);
        chk("R12", "we link", 32'(reg_we), 32'd1);
    endtask

    // R13: no read/write overlap, ALU fields quiet elsewhere, over all codes
    task automatic t_exclusive();
        for (int op = 0; op < 64; op++) begin
            drive(6'(op), 5'd2, 5'd4, 16'hABCD);
            chk("R13", $sformatf("op%0d rd&wr", op), 32'(mem_rd & mem_wr), 32'd0);
            if (!((op >= 10 && op <= 25) || (op >= 32 && op <= 47))) begin
                chk("R13", $sformatf("op%0d alu quiet", op),
                    {27'd0, alu_op, opb_imm}, 32'd0);
            end
        end
    endtask

    initial begin
        @(negedge clk);
        // R10: idle word (all zero) is a no-operation
        check_ctrl("R10", 0);
        t_fields();
        t_alu_imm();
        t_alu_reg();
        t_mem();
        t_jumps();
        t_stack_trap();
        t_nop();
        t_illegal();
        t_dest_zero();
        t_exclusive();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule